// File: doc/BRIEF.md
# Load/Store Function Unit

This block carries a single load or store through a scoreboard-driven out-of-order core, from the moment it is issued to the moment it retires. Issue hands it three decode bits (store or load, write back the address, use the immediate) and an immediate. The unit then asks for the operands it needs: the base, an index when no immediate is used, and store data for stores. It adds base and offset into an effective-address register and asks for leave to publish that address. After that it either reads memory and asks to write the loaded value to a register, or asks for leave to store and writes memory.

Every step is gated by a request/go pair with the external dependency logic. A request is held for as many cycles as needed. A one-cycle go retires it, and the request is low in the next cycle. A go may arrive in the same cycle as the request first rises, so each go input may be tied directly to its own request output. The memory side is a single-cycle port with combinational read data.

Top module: `lsfu_top`

## Requirements
- R1: An issue is accepted only while `busy_o` is low. `busy_o` is high from the cycle after the accepting edge. An issue presented while busy changes nothing and produces no extra memory access or write-back.
- R2: In the cycle after issue, `rd_req_o[0]` (base) is always high. `rd_req_o[1]` (index) is high only when the immediate flag is clear. `rd_req_o[2]` (store data) is high only for a store.
- R3: Each of the seven requests stays high until its go input is seen high at a clock edge, and is low in the following cycle. A go arriving in the same cycle the request rises is accepted.
- R4: The effective address is the base plus either the index or the sign-extended immediate, modulo 2^DATA_W.
- R5: `ad_req_o` rises only in a cycle where `ea_o` already holds the final sum, and `ea_o` does not change while `ad_req_o` is high.
- R6: For a load, after the address go, `mem_rd_en_o` is high for exactly one cycle with `mem_addr_o` equal to the effective address. The data read in that cycle then appears on `wr_ld_data_o` while `wr_req_o[0]` is held.
- R7: For a store, `st_req_o` rises after the address go once the store data has been read. `mem_wr_en_o` is high exactly in the store-go cycle, with `mem_addr_o` equal to this operation's effective address and `mem_wr_data_o` equal to the store data.
- R8: When the update flag is set, `wr_req_o[1]` is raised after the address go with `wr_ea_data_o` equal to the effective address. When the flag is clear, `wr_req_o[1]` never rises.
- R9: After the last required handshake completes (store go or load write-back go, plus the address write-back go if requested), `busy_o` falls and all requests are low.
- R10: `st_req_o` never rises for a load, and `wr_req_o[0]` never rises for a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | Issue strobe |
| issue_store_i | input | 1 | 1 = store, 0 = load |
| issue_upd_i | input | 1 | Also write the effective address back |
| issue_imm_vld_i | input | 1 | Use the immediate instead of the index operand |
| issue_imm_i | input | IMM_W | Immediate offset (signed) |
| busy_o | output | 1 | Unit holds an operation |
| rd_req_o | output | 3 | Operand read requests: [0] base, [1] index, [2] store data |
| rd_go_i | input | 3 | Operand read go pulses |
| opnd_a_i | input | DATA_W | Base operand, valid with rd_go_i[0] |
| opnd_b_i | input | DATA_W | Index operand, valid with rd_go_i[1] |
| opnd_c_i | input | DATA_W | Store data, valid with rd_go_i[2] |
| wr_req_o | output | 2 | Write-back requests: [0] load data, [1] effective address |
| wr_go_i | input | 2 | Write-back go pulses |
| wr_ld_data_o | output | DATA_W | Loaded data for write port 0 |
| wr_ea_data_o | output | DATA_W | Effective address for write port 1 |
| ad_req_o | output | 1 | Address-valid request |
| ad_go_i | input | 1 | Address-valid go |
| ea_o | output | DATA_W | Effective address register |
| st_req_o | output | 1 | Store request |
| st_go_i | input | 1 | Store go |
| mem_addr_o | output | DATA_W | Memory address |
| mem_rd_en_o | output | 1 | Memory read enable |
| mem_rd_data_i | input | DATA_W | Memory read data, same cycle as read enable |
| mem_wr_en_o | output | 1 | Memory write enable |
| mem_wr_data_o | output | DATA_W | Memory write data |

## Verification
A sequencer stuck in a waiting state shows within a handful of cycles: `busy_o` stays high and a request never drops. A request cell that misses a same-cycle go leaves its request high in the cycle after the go, so the next check sees it at once. An address register loaded one edge late shows as a wrong `ea_o` in the very cycle `ad_req_o` rises. It also shows as a memory access tagged with the previous operation's address, which the scoreboard flags at that access. An issue taken while busy shows as an unexpected access or write-back with no matching expected item.

// File: rtl/lsfu_pkg.sv
package lsfu_pkg;

   // handshake slot indices; req/go vectors follow this order
   localparam int HS_RD_A  = 0;
   localparam int HS_RD_B  = 1;
   localparam int HS_RD_C  = 2;
   localparam int HS_WR_LD = 3;
   localparam int HS_WR_EA = 4;
   localparam int HS_AD    = 5;
   localparam int HS_ST    = 6;
   localparam int HS_N     = 7;
   localparam int RD_N     = 3;
   localparam int WR_N     = 2;

   typedef enum logic [2:0] {
      S_IDLE  = 3'd0,
      S_OPER  = 3'd1,
      S_ADDR  = 3'd2,
      S_LDRD  = 3'd3,
      S_LDWB  = 3'd4,
      S_ST    = 3'd5,
      S_DRAIN = 3'd6
   } lsfu_state_e;

   typedef struct packed {
      logic is_store;
      logic upd;
      logic imm_vld;
   } lsfu_op_t;

endpackage

// File: rtl/lsfu_hs.sv
module lsfu_hs (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic go_i,
   output logic req_o,
   output logic fire_o
);
   logic req_q;

   always_ff @(posedge clk) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= (req_q & ~go_i) | set_i;
   end

   assign req_o  = req_q;
   assign fire_o = req_q & go_i;

   AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o |=> !req_o);                                   // R3
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && !go_i) |=> req_o);                          // R3
   AST_SET_WHEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |-> !req_o);                                    // R3
endmodule

// File: rtl/lsfu_opnd.sv
module lsfu_opnd
   import lsfu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              need_b_i,
   input  logic              need_c_i,
   input  logic [RD_N-1:0]   fire_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic [DATA_W-1:0] c_i,
   output logic [DATA_W-1:0] a_o,
   output logic [DATA_W-1:0] b_o,
   output logic [DATA_W-1:0] c_o,
   output logic              have_ab_o,
   output logic              have_c_o
);
   logic [DATA_W-1:0] din  [RD_N];
   logic [DATA_W-1:0] val_q[RD_N];
   logic [RD_N-1:0]   have_q;
   logic [RD_N-1:0]   need;

   assign din[0] = a_i;
   assign din[1] = b_i;
   assign din[2] = c_i;
   assign need   = {need_c_i, need_b_i, 1'b1};

   for (genvar k = 0; k < RD_N; k++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            have_q[k] <= 1'b1;
            val_q[k]  <= '0;
         end else if (clr_i) begin
            have_q[k] <= ~need[k];
         end else if (fire_i[k]) begin
            have_q[k] <= 1'b1;
            val_q[k]  <= din[k];
         end
      end

      AST_ONE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
         fire_i[k] |-> !have_q[k]);                         // R2
   end

   assign a_o       = val_q[0];
   assign b_o       = val_q[1];
   assign c_o       = val_q[2];
   assign have_ab_o = have_q[0] & have_q[1];
   assign have_c_o  = have_q[2];
endmodule

// File: rtl/lsfu_agen.sv
module lsfu_agen #(
   parameter int DATA_W   = 32,
   parameter int IMM_W    = 12,
   parameter bit SEXT_IMM = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic [IMM_W-1:0]  imm_i,
   input  logic              imm_vld_i,
   input  logic              load_i,
   output logic [DATA_W-1:0] ea_o
);
   localparam int PAD_W = DATA_W - IMM_W;

   if (IMM_W < 1 || IMM_W > DATA_W) begin : g_bad_imm
      $error("lsfu_agen: IMM_W must lie in 1..DATA_W");
   end

   logic [DATA_W-1:0] imm_ext;
   logic [DATA_W-1:0] offs;
   logic [DATA_W-1:0] sum;
   logic [DATA_W-1:0] ea_q;

   if (PAD_W == 0) begin : g_nopad
      assign imm_ext = imm_i;
   end else if (SEXT_IMM) begin : g_sext
      assign imm_ext = {{PAD_W{imm_i[IMM_W-1]}}, imm_i};
   end else begin : g_zext
      assign imm_ext = {{PAD_W{1'b0}}, imm_i};
   end

   assign offs = imm_vld_i ? imm_ext : b_i;
   assign sum  = a_i + offs;

   always_ff @(posedge clk) begin
      if (!rst_n)      ea_q <= '0;
      else if (load_i) ea_q <= sum;
   end

   assign ea_o = ea_q;
endmodule

// File: rtl/lsfu_ctrl.sv
module lsfu_ctrl
   import lsfu_pkg::*;
#(
   parameter int IMM_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             issue_i,
   input  lsfu_op_t         op_i,
   input  logic [IMM_W-1:0] imm_i,
   input  logic             have_ab_i,
   input  logic             have_c_i,
   input  logic [HS_N-1:0]  req_i,
   input  logic [HS_N-1:0]  fire_i,
   output logic             accept_o,
   output lsfu_op_t         op_o,
   output logic [IMM_W-1:0] imm_o,
   output logic [HS_N-1:0]  set_o,
   output logic             ea_load_o,
   output logic             ld_cap_o,
   output logic             rd_en_o,
   output logic             wr_en_o,
   output logic             busy_o
);
   lsfu_state_e      st_q, st_nx;
   lsfu_op_t         op_q;
   logic [IMM_W-1:0] imm_q;
   logic             ea_wb_open;

   assign accept_o   = issue_i && (st_q == S_IDLE);
   assign ea_wb_open = req_i[HS_WR_EA] & ~fire_i[HS_WR_EA];

   always_comb begin
      st_nx     = st_q;
      set_o     = '0;
      ea_load_o = 1'b0;
      ld_cap_o  = 1'b0;
      rd_en_o   = 1'b0;
      wr_en_o   = 1'b0;
      unique case (st_q)
         S_IDLE: if (accept_o) begin
            set_o[HS_RD_A] = 1'b1;
            set_o[HS_RD_B] = ~op_i.imm_vld;
            set_o[HS_RD_C] = op_i.is_store;
            st_nx          = S_OPER;
         end
         S_OPER: if (have_ab_i) begin
            ea_load_o    = 1'b1;
            set_o[HS_AD] = 1'b1;
            st_nx        = S_ADDR;
         end
         S_ADDR: if (fire_i[HS_AD]) begin
            set_o[HS_WR_EA] = op_q.upd;
            st_nx           = op_q.is_store ? S_ST : S_LDRD;
         end
         S_LDRD: begin
            rd_en_o         = 1'b1;
            ld_cap_o        = 1'b1;
            set_o[HS_WR_LD] = 1'b1;
            st_nx           = S_LDWB;
         end
         S_LDWB: if (fire_i[HS_WR_LD]) begin
            st_nx = ea_wb_open ? S_DRAIN : S_IDLE;
         end
         S_ST: begin
            set_o[HS_ST] = have_c_i & ~req_i[HS_ST];
            if (fire_i[HS_ST]) begin
               wr_en_o = 1'b1;
               st_nx   = ea_wb_open ? S_DRAIN : S_IDLE;
            end
         end
         S_DRAIN: if (fire_i[HS_WR_EA]) st_nx = S_IDLE;
         default: st_nx = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= S_IDLE;
         op_q  <= '0;
         imm_q <= '0;
      end else begin
         st_q <= st_nx;
         if (accept_o) begin
            op_q  <= op_i;
            imm_q <= imm_i;
         end
      end
   end

   assign op_o   = op_q;
   assign imm_o  = imm_q;
   assign busy_o = (st_q != S_IDLE);

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (req_i == '0));                           // R9
   AST_IDLE_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (fire_i == '0));                          // R9
   AST_BUSY_HOLDS_OP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && issue_i) |=> $stable(op_q));               // R1
   AST_ST_ONLY_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      req_i[HS_ST] |-> op_q.is_store);                      // R10
   AST_LDWB_ONLY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      req_i[HS_WR_LD] |-> !op_q.is_store);                  // R10
   AST_EAWB_ONLY_UPD: assert property (@(posedge clk) disable iff (!rst_n)
      req_i[HS_WR_EA] |-> op_q.upd);                        // R8
   AST_MEM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en_o && wr_en_o));                               // R6
   AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en_o |=> !rd_en_o);                                // R6
endmodule

// File: rtl/lsfu_top.sv
module lsfu_top
   import lsfu_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int IMM_W    = 12,
   parameter bit SEXT_IMM = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_i,
   input  logic              issue_store_i,
   input  logic              issue_upd_i,
   input  logic              issue_imm_vld_i,
   input  logic [IMM_W-1:0]  issue_imm_i,
   output logic              busy_o,
   output logic [2:0]        rd_req_o,
   input  logic [2:0]        rd_go_i,
   input  logic [DATA_W-1:0] opnd_a_i,
   input  logic [DATA_W-1:0] opnd_b_i,
   input  logic [DATA_W-1:0] opnd_c_i,
   output logic [1:0]        wr_req_o,
   input  logic [1:0]        wr_go_i,
   output logic [DATA_W-1:0] wr_ld_data_o,
   output logic [DATA_W-1:0] wr_ea_data_o,
   output logic              ad_req_o,
   input  logic              ad_go_i,
   output logic [DATA_W-1:0] ea_o,
   output logic              st_req_o,
   input  logic              st_go_i,
   output logic [DATA_W-1:0] mem_addr_o,
   output logic              mem_rd_en_o,
   input  logic [DATA_W-1:0] mem_rd_data_i,
   output logic              mem_wr_en_o,
   output logic [DATA_W-1:0] mem_wr_data_o
);
   if (DATA_W < 2) begin : g_bad_data
      $error("lsfu_top: DATA_W must be at least 2");
   end

   logic [HS_N-1:0]   go_v, req_v, fire_v, set_v;
   lsfu_op_t          op_in, op_q;
   logic [IMM_W-1:0]  imm_q;
   logic              accept, ea_load, ld_cap, have_ab, have_c;
   logic [DATA_W-1:0] a_q, b_q, c_q, ea_q, ld_q;

   assign go_v  = {st_go_i, ad_go_i, wr_go_i, rd_go_i};
   assign op_in = '{is_store: issue_store_i, upd: issue_upd_i,
                    imm_vld: issue_imm_vld_i};

   for (genvar h = 0; h < HS_N; h++) begin : g_hs
      lsfu_hs u_hs (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (set_v[h]),
         .go_i  (go_v[h]),
         .req_o (req_v[h]),
         .fire_o(fire_v[h])
      );
   end

   lsfu_ctrl #(.IMM_W(IMM_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .issue_i  (issue_i),
      .op_i     (op_in),
      .imm_i    (issue_imm_i),
      .have_ab_i(have_ab),
      .have_c_i (have_c),
      .req_i    (req_v),
      .fire_i   (fire_v),
      .accept_o (accept),
      .op_o     (op_q),
      .imm_o    (imm_q),
      .set_o    (set_v),
      .ea_load_o(ea_load),
      .ld_cap_o (ld_cap),
      .rd_en_o  (mem_rd_en_o),
      .wr_en_o  (mem_wr_en_o),
      .busy_o   (busy_o)
   );

   lsfu_opnd #(.DATA_W(DATA_W)) u_opnd (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (accept),
      .need_b_i (~issue_imm_vld_i),
      .need_c_i (issue_store_i),
      .fire_i   (fire_v[RD_N-1:0]),
      .a_i      (opnd_a_i),
      .b_i      (opnd_b_i),
      .c_i      (opnd_c_i),
      .a_o      (a_q),
      .b_o      (b_q),
      .c_o      (c_q),
      .have_ab_o(have_ab),
      .have_c_o (have_c)
   );

   lsfu_agen #(.DATA_W(DATA_W), .IMM_W(IMM_W), .SEXT_IMM(SEXT_IMM)) u_agen (
      .clk      (clk),
      .rst_n    (rst_n),
      .a_i      (a_q),
      .b_i      (b_q),
      .imm_i    (imm_q),
      .imm_vld_i(op_q.imm_vld),
      .load_i   (ea_load),
      .ea_o     (ea_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)      ld_q <= '0;
      else if (ld_cap) ld_q <= mem_rd_data_i;
   end

   assign rd_req_o      = req_v[HS_RD_C:HS_RD_A];
   assign wr_req_o      = req_v[HS_WR_EA:HS_WR_LD];
   assign ad_req_o      = req_v[HS_AD];
   assign st_req_o      = req_v[HS_ST];
   assign ea_o          = ea_q;
   assign wr_ea_data_o  = ea_q;
   assign wr_ld_data_o  = ld_q;
   assign mem_addr_o    = ea_q;
   assign mem_wr_data_o = c_q;

   AST_AD_AFTER_OPS: assert property (@(posedge clk) disable iff (!rst_n)
      ad_req_o |-> have_ab);                                // R5
   AST_AD_EA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (ad_req_o && $past(ad_req_o)) |-> $stable(ea_o));     // R5
   AST_WR_NOT_BEFORE_AD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en_o |-> (!ad_req_o && have_c));               // R7
   AST_RD_NOT_BEFORE_AD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en_o |-> !ad_req_o);                           // R6
   AST_ISSUE_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && busy_o) |=> !$rose(rd_req_o[0]));         // R1
endmodule

// File: tb/tb_lsfu_top.sv
module tb_lsfu_top;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 32;
   localparam int IW = 12;
   localparam logic [DW-1:0] MEM_KEY = 32'h5A5A_0F0F;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          issue = 1'b0, i_st = 1'b0, i_upd = 1'b0, i_imv = 1'b0;
   logic [IW-1:0] i_imm = '0;
   logic [DW-1:0] opa = '0, opb = '0, opc = '0;
   logic          busy;
   logic [2:0]    rd_req, rd_go;
   logic [1:0]    wr_req, wr_go;
   logic [DW-1:0] wr_ld_d, wr_ea_d, ea, maddr, mrdata, mwdata;
   logic          ad_req, ad_go, st_req, st_go, mrd, mwr;

   logic          tie = 1'b1;
   logic [6:0]    go_d = '0;
   logic [2:0]    cnt [7];
   logic [6:0]    req_v, go_v;

   int n_vec = 0, n_bad = 0;
   logic [DW-1:0] q_ea[$], q_rd[$], q_ld[$], q_eawb[$], q_wa[$], q_wd[$];
   logic          cur_store = 1'b0;
   logic          ad_prev = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign req_v  = {st_req, ad_req, wr_req, rd_req};
   assign go_v   = tie ? req_v : go_d;
   assign rd_go  = go_v[2:0];
   assign wr_go  = go_v[4:3];
   assign ad_go  = go_v[5];
   assign st_go  = go_v[6];
   assign mrdata = maddr ^ MEM_KEY;

   lsfu_top #(.DATA_W(DW), .IMM_W(IW)) dut (
      .clk(clk), .rst_n(rst_n), .issue_i(issue), .issue_store_i(i_st),
      .issue_upd_i(i_upd), .issue_imm_vld_i(i_imv), .issue_imm_i(i_imm),
      .busy_o(busy), .rd_req_o(rd_req), .rd_go_i(rd_go),
      .opnd_a_i(opa), .opnd_b_i(opb), .opnd_c_i(opc),
      .wr_req_o(wr_req), .wr_go_i(wr_go), .wr_ld_data_o(wr_ld_d),
      .wr_ea_data_o(wr_ea_d), .ad_req_o(ad_req), .ad_go_i(ad_go), .ea_o(ea),
      .st_req_o(st_req), .st_go_i(st_go), .mem_addr_o(maddr),
      .mem_rd_en_o(mrd), .mem_rd_data_i(mrdata), .mem_wr_en_o(mwr),
      .mem_wr_data_o(mwdata));

   // delayed go responder: slot i waits (i % 3) cycles before a 1-cycle go
   always @(negedge clk) begin
      for (int i = 0; i < 7; i++) begin
         if (go_d[i]) begin
            go_d[i] <= 1'b0;
            cnt[i]  <= '0;
         end else if (req_v[i] && !tie) begin
            if (cnt[i] == 3'(i % 3)) go_d[i] <= 1'b1;
            else                     cnt[i] <= cnt[i] + 3'd1;
         end else begin
            cnt[i] <= '0;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic pop_chk(ref logic [DW-1:0] q[$], input logic [DW-1:0] act,
                          input string tag);
      if (q.size() == 0) chk(1'b0, {tag, " unexpected"}, act, '0);
      else begin
         logic [DW-1:0] e;
         e = q.pop_front();
         chk(act == e, tag, act, e);
      end
   endtask

   // monitor: samples mid-low-phase, after all go/req values have settled
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (rst_n) begin
            if (ad_req && !ad_prev) pop_chk(q_ea, ea, "R4/R5 ea at ad rise");
            if (mrd) pop_chk(q_rd, maddr, "R6 read addr");
            if (wr_req[0] && wr_go[0]) pop_chk(q_ld, wr_ld_d, "R6 load wb data");
            if (wr_req[1] && wr_go[1]) pop_chk(q_eawb, wr_ea_d, "R8 ea wb data");
            if (mwr) begin
               pop_chk(q_wa, maddr, "R7 store addr");
               pop_chk(q_wd, mwdata, "R7 store data");
            end
            if (st_req && !cur_store) chk(1'b0, "R10 st_req on load", 1, 0);
            if (wr_req[0] && cur_store) chk(1'b0, "R10 load wb on store", 1, 0);
         end
         ad_prev = ad_req;
      end
   end

   task automatic run_op(input bit store, input bit upd, input bit imv,
                         input logic [IW-1:0] imm, input logic [DW-1:0] a,
                         input logic [DW-1:0] b, input logic [DW-1:0] c,
                         input bit stray);
      logic [DW-1:0] off, e;
      int            t;
      off = imv ? {{(DW-IW){imm[IW-1]}}, imm} : b;
      e   = a + off;
      q_ea.push_back(e);
      if (store) begin
         q_wa.push_back(e);
         q_wd.push_back(c);
      end else begin
         q_rd.push_back(e);
         q_ld.push_back(e ^ MEM_KEY);
      end
      if (upd) q_eawb.push_back(e);
      @(negedge clk);
      cur_store = store;
      i_st = store; i_upd = upd; i_imv = imv; i_imm = imm;
      opa = a; opb = b; opc = c;
      issue = 1'b1;
      @(negedge clk);
      issue = 1'b0;
      #1;
      chk(busy === 1'b1, "R1 busy after issue", DW'(busy), 1);
      chk(rd_req === {store, ~imv, 1'b1}, "R2 operand request mask",
          DW'(rd_req), DW'({store, ~imv, 1'b1}));
      t = 0;
      while (busy && t < 300) begin
         @(negedge clk);
         t++;
         if (stray && t == 2) begin
            i_st = ~store; i_upd = 1'b1; i_imv = 1'b0; issue = 1'b1;
         end else begin
            issue = 1'b0;
         end
      end
      issue = 1'b0;
      #3;
      chk(t < 300, "R9 busy falls (watchdog)", DW'(t), 0);
      chk(req_v === '0, "R9 all requests low when idle", DW'(req_v), 0);
      chk((q_ea.size() + q_rd.size() + q_ld.size() + q_eawb.size()
           + q_wa.size() + q_wd.size()) == 0, "R9 all expected items seen",
          DW'(q_ea.size() + q_rd.size() + q_ld.size() + q_eawb.size()
           + q_wa.size()), 0);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 7; i++) cnt[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(busy === 1'b0, "R9 reset busy low", DW'(busy), 0);
      chk(req_v === '0, "R9 reset requests low", DW'(req_v), 0);
      chk({mrd, mwr} === 2'b00, "R6/R7 reset memory idle", DW'({mrd, mwr}), 0);

      // R3: combinational go tie
      tie = 1'b1;
      run_op(0, 0, 1, 12'h004, 32'h0000_0100, 32'h0, 32'h0, 0);
      run_op(0, 0, 0, 12'h000, 32'h0000_2000, 32'h0000_0034, 32'h0, 0);
      run_op(1, 0, 1, 12'hFF8, 32'h0000_0040, 32'h0, 32'hCAFE_F00D, 0); // R4 negative imm
      run_op(1, 1, 1, 12'h008, 32'hFFFF_FFFC, 32'h0, 32'h1234_5678, 0); // R4 wrap
      // R3: held requests, delayed go
      tie = 1'b0;
      run_op(1, 1, 0, 12'h000, 32'h0000_0300, 32'h0000_0006, 32'hA1A2_A3A4, 0);
      run_op(0, 1, 1, 12'h7FF, 32'h1000_0000, 32'h0, 32'h0, 0);
      // R1: stray issue while busy
      run_op(0, 0, 0, 12'h000, 32'h0000_0500, 32'h0000_0010, 32'h0, 1);
      run_op(1, 0, 1, 12'h001, 32'h0000_0600, 32'h0, 32'h0BAD_BEEF, 1);
      // R7: back-to-back stores, each must carry its own address
      run_op(1, 0, 1, 12'h010, 32'h0000_0700, 32'h0, 32'h1111_1111, 0);
      tie = 1'b1;
      run_op(1, 0, 0, 12'h000, 32'h0000_0800, 32'h0000_0002, 32'h2222_2222, 0);
      run_op(0, 1, 0, 12'h000, 32'h0000_0900, 32'hFFFF_FFFF, 32'h0, 0);
      repeat (4) @(negedge clk);
      #1;
      chk(busy === 1'b0, "R9 final idle", DW'(busy), 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule